// File: doc/BRIEF.md
# Firmware Image Validator and Loader

This block takes a firmware image that already sits in a word-addressed local image RAM. It checks the image and then copies each of its code blocks into the instruction or data memory of an attached processor. A pulse on `start_i` begins a load. The block reads the image through a synchronous read port: data comes back one cycle after the address is issued. It produces a stream of memory-write commands, and each command carries a command code, a target word address and a data word. At the end it raises `done_o` for one cycle and reports a result code on `err_code_o`. The code is zero when the load succeeds, and each kind of failure has its own nonzero value.

The image has three header words, followed by a payload. The header words are, in order: a magic word, an identity word and a payload size counted in 32-bit words. The payload starts with a block table of one-word entries. Each entry holds a type in bits [31:24] and a payload offset in bits [23:0], and the table ends at an entry of type 0x0F. Each entry points to a code block inside the payload. A code block has a start-address word, then a length word, then that many data words. Payload word k is stored at image RAM address 3+k.

When the magic word appears byte-reversed, the block byte-reverses every word it reads. This lets images written with either byte order load the same way. The configuration inputs select the following: the target number, a reduced-memory device mode, a smaller-instruction-memory target variant, and the target's running status.

Top module: `fwl_top`

## Requirements
- R1: A magic word of 0xFEEDF00D is accepted. Any value other than that word or its byte-reversed form ends the load with code 1.
- R2: A magic word of 0x0DF0EDFE marks a swapped image. Every word is then byte-reversed before use, and the writes issued are identical to those of the same image in native order.
- R3: Image length in bytes (`img_bytes_i`) must equal the payload size × 4 + 12, or the load ends with code 2.
- R4: Bits [27:24] of the identity word must equal `target_num_i`, or the load ends with code 3. When `reduced_mode_i` is 1, bits [31:28] must be zero, or the load ends with code 4. When `reduced_mode_i` is 0, those bits are ignored.
- R5: When `target_running_i` is 1, the load ends with code 5 and issues no write. The header checks run in the order R3, R4 (identity), R4 (device), R5, and the first one that fails sets the code.
- R6: Table entries are scanned from payload word 0. If no entry with type 0x0F appears within the payload, the load ends with code 6.
- R7: A block offset must be at least the entry count plus 1. The offset plus 2 must not exceed the payload size. Otherwise the load ends with code 7.
- R8: Type 0x00 blocks are written with command 0x11 and type 0x01 blocks with command 0x13. Any other type ends the load with code 8.
- R9: The start address plus the length must not exceed the limit, or the load ends with code 9. The instruction limit is 0x800 when both `reduced_mode_i` and `small_variant_i` are 1, and 0x1000 otherwise. The data limit is 0x800 when `reduced_mode_i` is 1, and 0x1000 otherwise.
- R10: The offset plus 2 plus the length must not exceed the payload size, or the load ends with code 10.
- R11: The data words of a block are written one per cycle, in payload order, to consecutive addresses starting at the block's start address. Blocks are processed in table order, and a zero-length block issues no write.
- R12: Every load ends with a one-cycle `done_o` pulse and a code on `err_code_o` (0 on success). A block that fails a check issues no write, but blocks that passed before it keep their writes.
- R13: After reset, `busy_o`, `done_o` and `wr_valid_o` are 0 and `err_code_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted while idle |
| img_bytes_i | input | IMG_AW+2 | Image length in bytes |
| target_num_i | input | 4 | Number of the target processor |
| reduced_mode_i | input | 1 | Reduced-memory device mode |
| small_variant_i | input | 1 | Target has the smaller instruction memory |
| target_running_i | input | 1 | Target running status |
| img_rd_en_o | output | 1 | Image RAM read enable |
| img_addr_o | output | IMG_AW | Image RAM word address |
| img_rdata_i | input | 32 | Image RAM read data, one cycle after the request |
| wr_valid_o | output | 1 | Memory-write command valid |
| wr_cmd_o | output | 8 | Write command code (0x11 instruction, 0x13 data) |
| wr_addr_o | output | TA_W | Target word address |
| wr_data_o | output | 32 | Data word |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | One-cycle end-of-load pulse |
| err_code_o | output | 4 | Result code of the last load |

## Verification
A two-block reference image, holding one instruction block and one data block, is loaded in native order and then byte-reversed. Matching write streams show that the swap is undone word by word, not only detected. Each failure case changes exactly one field of that reference image: the magic word, the length, the identity nibbles, the running flag, the end marker, an offset on either side of its window, the type, the address against each memory mode, or a length that overruns the payload. Each case therefore separates its own error code from the others. It also shows whether writes for the blocks that passed earlier still appear. Sibling cases that must pass confirm that each limit is inclusive. These are a data block that ends exactly at 0x800, the same instruction block without reduced mode, a zero-length block, and nonzero device bits outside reduced mode.

// File: rtl/fwl_pkg.sv
package fwl_pkg;
    localparam logic [31:0] MAGIC      = 32'hFEEDF00D;
    localparam logic [31:0] MAGIC_SWAP = 32'h0DF0EDFE;
    localparam int unsigned HDR_WORDS  = 3;
    localparam int unsigned CB_HDR     = 2;
    localparam logic [7:0]  TYPE_INSTR = 8'h00;
    localparam logic [7:0]  TYPE_DATA  = 8'h01;
    localparam logic [7:0]  TYPE_END   = 8'h0F;
    localparam logic [7:0]  CMD_INSTR  = 8'h11;
    localparam logic [7:0]  CMD_DATA   = 8'h13;

    typedef enum logic [3:0] {
        S_IDLE, S_MAGIC, S_ID, S_SIZE, S_HDR, S_SCAN,
        S_BLK, S_ENT, S_BADDR, S_BLEN, S_BCHK, S_COPY
    } state_t;

    typedef enum logic [3:0] {
        E_OK = 4'd0, E_MAGIC = 4'd1, E_LEN = 4'd2, E_ID = 4'd3,
        E_DEV = 4'd4, E_RUN = 4'd5, E_NO_END = 4'd6, E_OFFSET = 4'd7,
        E_TYPE = 4'd8, E_MEM = 4'd9, E_FIT = 4'd10
    } err_t;
endpackage

// File: rtl/fwl_swap.sv
module fwl_swap #(
    parameter int unsigned W = 32
) (
    input  logic         en_i,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] word_o
);
    localparam int unsigned NB = W / 8;
    logic [W-1:0] rev;

    for (genvar g = 0; g < NB; g++) begin : g_byte
        assign rev[8*g +: 8] = raw_i[8*(NB-1-g) +: 8];
    end

    assign word_o = en_i ? rev : raw_i;
endmodule

// File: rtl/fwl_limit.sv
module fwl_limit #(
    parameter int unsigned MEM_BIG   = 4096,
    parameter int unsigned MEM_SMALL = 2048
) (
    input  logic        reduced_i,
    input  logic        small_var_i,
    input  logic        is_data_i,
    input  logic [31:0] start_i,
    input  logic [31:0] len_i,
    output logic        ovf_o
);
    logic [32:0] limit;
    logic [32:0] end_pos;

    always_comb begin
        if (is_data_i) limit = reduced_i ? 33'(MEM_SMALL) : 33'(MEM_BIG);
        else           limit = (reduced_i && small_var_i) ? 33'(MEM_SMALL) : 33'(MEM_BIG);
        end_pos = {1'b0, start_i} + {1'b0, len_i};
        ovf_o   = end_pos > limit;
    end
endmodule

// File: rtl/fwl_top.sv
module fwl_top
    import fwl_pkg::*;
#(
    parameter int unsigned IMG_AW    = 10,
    parameter int unsigned MEM_BIG   = 4096,
    parameter int unsigned MEM_SMALL = 2048,
    localparam int unsigned LEN_W    = IMG_AW + 2,
    localparam int unsigned TA_W     = $clog2(MEM_BIG)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [LEN_W-1:0]  img_bytes_i,
    input  logic [3:0]        target_num_i,
    input  logic              reduced_mode_i,
    input  logic              small_variant_i,
    input  logic              target_running_i,
    output logic              img_rd_en_o,
    output logic [IMG_AW-1:0] img_addr_o,
    input  logic [31:0]       img_rdata_i,
    output logic              wr_valid_o,
    output logic [7:0]        wr_cmd_o,
    output logic [TA_W-1:0]   wr_addr_o,
    output logic [31:0]       wr_data_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [3:0]        err_code_o
);
    typedef struct packed {
        state_t            state;
        logic              swap;
        logic [31:0]       id;
        logic [31:0]       size;
        logic [IMG_AW-1:0] idx;
        logic [IMG_AW-1:0] nblk;
        logic [IMG_AW-1:0] bi;
        logic [7:0]        etype;
        logic [23:0]       off;
        logic [31:0]       baddr;
        logic [31:0]       blen;
        logic [IMG_AW-1:0] ptr;
        logic [IMG_AW-1:0] j;
        logic              wr_valid;
        logic [7:0]        wr_cmd;
        logic [TA_W-1:0]   wr_addr;
        logic [31:0]       wr_data;
        logic              done;
        err_t              err;
    } regs_t;

    regs_t q, d;
    logic [31:0] word;
    logic        ovf;
    logic [31:0] off_ext;
    logic [33:0] len_calc;
    logic        off_bad;
    logic        fit_bad;

    fwl_swap #(.W(32)) u_swap (
        .en_i   (q.swap),
        .raw_i  (img_rdata_i),
        .word_o (word)
    );

    fwl_limit #(.MEM_BIG(MEM_BIG), .MEM_SMALL(MEM_SMALL)) u_limit (
        .reduced_i   (reduced_mode_i),
        .small_var_i (small_variant_i),
        .is_data_i   (q.etype == TYPE_DATA),
        .start_i     (q.baddr),
        .len_i       (q.blen),
        .ovf_o       (ovf)
    );

    always_comb begin
        d           = q;
        d.wr_valid  = 1'b0;
        d.done      = 1'b0;
        img_rd_en_o = 1'b0;
        img_addr_o  = '0;
        off_ext     = {8'd0, word[23:0]};
        len_calc    = {q.size, 2'b00} + 34'(HDR_WORDS * 4);
        off_bad     = ({1'b0, off_ext} + 33'(CB_HDR) > {1'b0, q.size})
                   || (off_ext < 32'(q.nblk) + 32'd1);
        fit_bad     = ({10'd0, q.off} + 34'(CB_HDR) + {2'b0, q.blen}) > {2'b0, q.size};

        case (q.state)
            S_IDLE: if (start_i) begin
                img_rd_en_o = 1'b1;
                d.swap      = 1'b0;
                d.err       = E_OK;
                d.state     = S_MAGIC;
            end
            S_MAGIC: begin
                if (img_rdata_i == MAGIC || img_rdata_i == MAGIC_SWAP) begin
                    d.swap      = (img_rdata_i == MAGIC_SWAP);
                    img_rd_en_o = 1'b1;
                    img_addr_o  = IMG_AW'(1);
                    d.state     = S_ID;
                end else begin
                    d.err = E_MAGIC; d.done = 1'b1; d.state = S_IDLE;
                end
            end
            S_ID: begin
                d.id        = word;
                img_rd_en_o = 1'b1;
                img_addr_o  = IMG_AW'(2);
                d.state     = S_SIZE;
            end
            S_SIZE: begin
                d.size  = word;
                d.state = S_HDR;
            end
            S_HDR: begin
                d.done  = 1'b1;
                d.state = S_IDLE;
                if (len_calc != 34'(img_bytes_i))             d.err = E_LEN;
                else if (q.id[27:24] != target_num_i)          d.err = E_ID;
                else if (reduced_mode_i && q.id[31:28] != 4'd0) d.err = E_DEV;
                else if (target_running_i)                     d.err = E_RUN;
                else if (q.size == 32'd0)                      d.err = E_NO_END;
                else begin
                    d.done      = 1'b0;
                    d.idx       = '0;
                    img_rd_en_o = 1'b1;
                    img_addr_o  = IMG_AW'(HDR_WORDS);
                    d.state     = S_SCAN;
                end
            end
            S_SCAN: begin
                if (word[31:24] == TYPE_END) begin
                    d.nblk  = q.idx;
                    d.bi    = '0;
                    d.state = S_BLK;
                end else if (32'(q.idx) + 32'd1 >= q.size) begin
                    d.err = E_NO_END; d.done = 1'b1; d.state = S_IDLE;
                end else begin
                    d.idx       = q.idx + 1'b1;
                    img_rd_en_o = 1'b1;
                    img_addr_o  = IMG_AW'(HDR_WORDS) + q.idx + 1'b1;
                end
            end
            S_BLK: begin
                if (q.bi == q.nblk) begin
                    d.done = 1'b1; d.state = S_IDLE;
                end else begin
                    img_rd_en_o = 1'b1;
                    img_addr_o  = IMG_AW'(HDR_WORDS) + q.bi;
                    d.state     = S_ENT;
                end
            end
            S_ENT: begin
                d.etype = word[31:24];
                d.off   = word[23:0];
                if (off_bad) begin
                    d.err = E_OFFSET; d.done = 1'b1; d.state = S_IDLE;
                end else if (word[31:24] != TYPE_INSTR && word[31:24] != TYPE_DATA) begin
                    d.err = E_TYPE; d.done = 1'b1; d.state = S_IDLE;
                end else begin
                    img_rd_en_o = 1'b1;
                    img_addr_o  = IMG_AW'(HDR_WORDS) + IMG_AW'(word[23:0]);
                    d.state     = S_BADDR;
                end
            end
            S_BADDR: begin
                d.baddr     = word;
                img_rd_en_o = 1'b1;
                img_addr_o  = IMG_AW'(HDR_WORDS + 1) + IMG_AW'(q.off);
                d.state     = S_BLEN;
            end
            S_BLEN: begin
                d.blen  = word;
                d.state = S_BCHK;
            end
            S_BCHK: begin
                if (ovf) begin
                    d.err = E_MEM; d.done = 1'b1; d.state = S_IDLE;
                end else if (fit_bad) begin
                    d.err = E_FIT; d.done = 1'b1; d.state = S_IDLE;
                end else if (q.blen == 32'd0) begin
                    d.bi    = q.bi + 1'b1;
                    d.state = S_BLK;
                end else begin
                    img_rd_en_o = 1'b1;
                    img_addr_o  = IMG_AW'(HDR_WORDS + CB_HDR) + IMG_AW'(q.off);
                    d.ptr       = IMG_AW'(HDR_WORDS + CB_HDR + 1) + IMG_AW'(q.off);
                    d.j         = '0;
                    d.state     = S_COPY;
                end
            end
            S_COPY: begin
                d.wr_valid = 1'b1;
                d.wr_cmd   = (q.etype == TYPE_DATA) ? CMD_DATA : CMD_INSTR;
                d.wr_addr  = q.baddr[TA_W-1:0] + TA_W'(q.j);
                d.wr_data  = word;
                if (32'(q.j) + 32'd1 == q.blen) begin
                    d.bi    = q.bi + 1'b1;
                    d.state = S_BLK;
                end else begin
                    img_rd_en_o = 1'b1;
                    img_addr_o  = q.ptr;
                    d.ptr       = q.ptr + 1'b1;
                    d.j         = q.j + 1'b1;
                end
            end
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q       <= '0;
            q.state <= S_IDLE;
            q.err   <= E_OK;
        end else begin
            q <= d;
        end
    end

    assign wr_valid_o = q.wr_valid;
    assign wr_cmd_o   = q.wr_cmd;
    assign wr_addr_o  = q.wr_addr;
    assign wr_data_o  = q.wr_data;
    assign busy_o     = (q.state != S_IDLE);
    assign done_o     = q.done;
    assign err_code_o = q.err;

    // R8: only the two write command codes ever leave the block
    p_cmd_code_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_valid_o |-> (wr_cmd_o == CMD_INSTR || wr_cmd_o == CMD_DATA));

    // R11: back-to-back writes belong to one block and step the address by one
    p_addr_step_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_valid_o && $past(wr_valid_o)) |->
            (wr_addr_o == $past(wr_addr_o) + 1'b1 && $stable(wr_cmd_o)));

    // R12: the end-of-load indication lasts a single cycle
    p_done_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R9: in reduced mode no data write reaches the small limit
    p_data_limit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_valid_o && reduced_mode_i && wr_cmd_o == CMD_DATA) |->
            (32'(wr_addr_o) < MEM_SMALL));

    // R5: a refused load never emits a write in the cycle it ends
    p_run_nowrite_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && err_code_o == E_RUN) |-> !wr_valid_o);
endmodule

// File: tb/sim_fwl_top.sv
module sim_fwl_top;
    localparam int IMG_AW = 10;
    localparam int TA_W   = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [IMG_AW+1:0] img_bytes = '0;
    logic [3:0]        tnum = 4'd2;
    logic              reduced = 1'b0;
    logic              small_v = 1'b0;
    logic              running = 1'b0;
    logic              rd_en;
    logic [IMG_AW-1:0] rd_addr;
    logic [31:0]       rdata = '0;
    logic              wr_valid;
    logic [7:0]        wr_cmd;
    logic [TA_W-1:0]   wr_addr;
    logic [31:0]       wr_data;
    logic              busy;
    logic              done;
    logic [3:0]        err;

    always #2 clk = ~clk;

    fwl_top u0 (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .img_bytes_i(img_bytes),
        .target_num_i(tnum), .reduced_mode_i(reduced), .small_variant_i(small_v),
        .target_running_i(running), .img_rd_en_o(rd_en), .img_addr_o(rd_addr),
        .img_rdata_i(rdata), .wr_valid_o(wr_valid), .wr_cmd_o(wr_cmd),
        .wr_addr_o(wr_addr), .wr_data_o(wr_data), .busy_o(busy), .done_o(done),
        .err_code_o(err)
    );

    logic [31:0] mem [0:(1<<IMG_AW)-1];
    logic [31:0] pl  [0:63];
    logic [51:0] exp_q [$];
    int checks = 0;
    int failures = 0;
    string tag = "R13";

    always @(posedge clk) if (rd_en) rdata <= mem[rd_addr];

    task automatic check(input string t, input [51:0] got, input [51:0] expv);
        checks++;
        if (got !== expv) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h", t, got, expv);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && wr_valid) begin
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL %s unexpected write got=%0h exp=none", tag, {wr_cmd, wr_addr, wr_data});
            end else begin
                logic [51:0] e;
                e = exp_q.pop_front();
                check({tag, " write"}, {wr_cmd, wr_addr, wr_data}, e);
            end
        end
    end

    function automatic logic [31:0] bswap(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic load(input bit sw, input [3:0] tid, input [3:0] dev,
                        input int size, input int extra, input [31:0] magic);
        for (int i = 0; i < (1<<IMG_AW); i++) mem[i] = '0;
        mem[0] = magic;
        mem[1] = {dev, tid, 24'h0};
        mem[2] = size;
        for (int i = 0; i < size; i++) mem[3+i] = pl[i];
        if (sw) for (int i = 0; i < size + 3; i++) mem[i] = bswap(mem[i]);
        img_bytes = (IMG_AW+2)'(size*4 + 12 + extra);
    endtask

    task automatic expect_blk(input [7:0] cmd, input int addr, input int len, input int pidx);
        for (int i = 0; i < len; i++)
            exp_q.push_back({cmd, TA_W'(addr + i), pl[pidx + i]});
    endtask

    task automatic run(input string t, input [3:0] exp_err);
        tag = t;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!done) @(negedge clk);
        check({t, " code"}, 52'(err), 52'(exp_err));
        @(negedge clk);
        check({t, " done pulse"}, 52'(done), 52'(0));
        check({t, " pending writes"}, 52'(exp_q.size()), 52'(0));
        exp_q.delete();
    endtask

    task automatic ref_image();
        for (int i = 0; i < 64; i++) pl[i] = 32'h0;
        pl[0] = 32'h0000_0003; pl[1] = 32'h0100_0008; pl[2] = 32'h0F00_0000;
        pl[3] = 32'h10; pl[4] = 32'd3;
        pl[5] = 32'hA0A0_0001; pl[6] = 32'hA0A0_0002; pl[7] = 32'hA0A0_0003;
        pl[8] = 32'h7FE; pl[9] = 32'd2;
        pl[10] = 32'hD0D0_1111; pl[11] = 32'hD0D0_2222;
    endtask

    task automatic ref_expect();
        expect_blk(8'h11, 'h10, 3, 5);
        expect_blk(8'h13, 'h7FE, 2, 10);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired got=busy exp=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R13 reset state
        check("R13 busy", 52'(busy), 0);
        check("R13 done", 52'(done), 0);
        check("R13 wr_valid", 52'(wr_valid), 0);
        check("R13 code", 52'(err), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R8 R11 R12 native good image
        ref_image(); load(0, 4'd2, 4'd0, 12, 0, 32'hFEEDF00D); ref_expect();
        run("R1_R8_R11 native", 4'd0);
        // R2 swapped image
        ref_image(); load(1, 4'd2, 4'd0, 12, 0, 32'hFEEDF00D); ref_expect();
        run("R2 swapped", 4'd0);
        // R1 bad magic
        ref_image(); load(0, 4'd2, 4'd0, 12, 0, 32'hFEEDF00E);
        run("R1 bad magic", 4'd1);
        // R3 length mismatch
        ref_image(); load(0, 4'd2, 4'd0, 12, 4, 32'hFEEDF00D);
        run("R3 length", 4'd2);
        // R4 id mismatch
        ref_image(); load(0, 4'd1, 4'd0, 12, 0, 32'hFEEDF00D);
        run("R4 id", 4'd3);
        // R4 device bits in reduced mode
        reduced = 1'b1;
        ref_image(); load(0, 4'd2, 4'd3, 12, 0, 32'hFEEDF00D);
        run("R4 device reduced", 4'd4);
        // R4 device bits ignored outside reduced mode
        reduced = 1'b0;
        ref_image(); load(0, 4'd2, 4'd3, 12, 0, 32'hFEEDF00D); ref_expect();
        run("R4 device ignored", 4'd0);
        // R5 running target
        running = 1'b1;
        ref_image(); load(0, 4'd2, 4'd0, 12, 0, 32'hFEEDF00D);
        run("R5 running", 4'd5);
        running = 1'b0;
        // R6 no end marker
        ref_image(); pl[2] = 32'h0000_0003; load(0, 4'd2, 4'd0, 3, 0, 32'hFEEDF00D);
        run("R6 no end", 4'd6);
        // R7 offset below table end; block 0 still written (R12)
        ref_image(); pl[1] = 32'h0100_0001; load(0, 4'd2, 4'd0, 12, 0, 32'hFEEDF00D);
        expect_blk(8'h11, 'h10, 3, 5);
        run("R7_R12 offset low", 4'd7);
        // R7 offset above payload
        ref_image(); pl[1] = 32'h0100_000B; load(0, 4'd2, 4'd0, 12, 0, 32'hFEEDF00D);
        expect_blk(8'h11, 'h10, 3, 5);
        run("R7 offset high", 4'd7);
        // R8 bad type
        ref_image(); pl[0] = 32'h0200_0003; load(0, 4'd2, 4'd0, 12, 0, 32'hFEEDF00D);
        run("R8 type", 4'd8);
        // R9 reduced data limit: 0x7FE+2 = 0x800 passes
        reduced = 1'b1;
        ref_image(); load(0, 4'd2, 4'd0, 12, 0, 32'hFEEDF00D); ref_expect();
        run("R9 data edge", 4'd0);
        ref_image(); pl[8] = 32'h7FF; load(0, 4'd2, 4'd0, 12, 0, 32'hFEEDF00D);
        expect_blk(8'h11, 'h10, 3, 5);
        run("R9 data over", 4'd9);
        // R9 instruction limit for small variant
        small_v = 1'b1;
        ref_image(); pl[3] = 32'h7FF; load(0, 4'd2, 4'd0, 12, 0, 32'hFEEDF00D);
        run("R9 instr small", 4'd9);
        reduced = 1'b0;
        ref_image(); pl[3] = 32'h7FF; load(0, 4'd2, 4'd0, 12, 0, 32'hFEEDF00D);
        expect_blk(8'h11, 'h7FF, 3, 5); expect_blk(8'h13, 'h7FE, 2, 10);
        run("R9 instr big", 4'd0);
        small_v = 1'b0;
        // R10 block overruns payload
        ref_image(); pl[9] = 32'd3; load(0, 4'd2, 4'd0, 12, 0, 32'hFEEDF00D);
        expect_blk(8'h11, 'h10, 3, 5);
        run("R10 fit", 4'd10);
        // R11 zero-length block
        ref_image(); pl[4] = 32'd0; load(0, 4'd2, 4'd0, 12, 0, 32'hFEEDF00D);
        expect_blk(8'h13, 'h7FE, 2, 10);
        run("R11 zero length", 4'd0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule